// File: doc/BRIEF.md
# Bank Group Transition Counter

This block watches the stream of decoded memory commands on one channel and, for every rank, remembers the direction and bank group of the last column command (read or write) that rank received. When the next column command reaches the same rank, the pair is sorted into one of eight categories. A category is formed from three things: the direction of the earlier command, the direction of the later one, and whether the two used the same bank group. Each rank keeps eight saturating event counters, one per category, and a ninth counter that totals all counted pairs. Software or a later stage can turn any category into a share of the traffic by dividing it by the total.

The block takes one command per clock, already decoded upstream. Counters are read through a registered select port: a rank number and a slot number go in, and the value appears on the data output one clock later. A synchronous clear empties every counter and every remembered command. After that, the next column command on each rank only reloads its memory.

Top module: `bgt_transition_counter`

## Requirements
- R1: While `rst` is high at a rising edge, every counter, every remembered command and `rd_data` become zero. After reset every read slot returns 0.
- R2: The category index is {earlier direction, later direction, different-group bit}. Read is encoded as 0 and write as 1 on `cmd_wr`, so slot 0 is read-read same group and slot 7 is write-write different group.
- R3: The first column command a rank receives after reset or clear is stored as that rank's earlier command and adds nothing to any counter.
- R4: A cycle with `cmd_valid` low, or with `cmd_col` low (activate, precharge, refresh and similar), leaves the remembered commands and all counters unchanged. So does a command whose `cmd_rank` is not below NUM_RANKS.
- R5: Each rank keeps its own remembered command. A column command is compared only with the last column command of the same rank, whatever happened on other ranks in between.
- R6: A pair counts as same group exactly when the two `cmd_bg` values are equal. Any difference in them sets the different-group bit.
- R7: Slot 8 of a rank is the total. It increases by one with every counted pair of that rank, so it equals the sum of slots 0 to 7 as long as nothing has saturated.
- R8: Every counter, including the total, stops at 2^CNT_W-1 and stays there until reset or clear.
- R9: A high `clr` at a rising edge zeroes all counters and forgets the remembered command of every rank. A command presented in that same cycle is dropped.
- R10: `rd_data` is registered. After the edge at which `rd_rank`/`rd_sel` are sampled, it shows that counter's value as it stood before that edge. Slots 9 to 15 and ranks not below NUM_RANKS read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and remembered commands |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_col | input | 1 | The command is a column command (read or write) |
| cmd_wr | input | 1 | Direction of a column command: 0 read, 1 write |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bg | input | BG_W | Target bank group |
| rd_rank | input | RANK_W | Rank selected for readout |
| rd_sel | input | 4 | Slot selected for readout: 0-7 categories, 8 total |
| rd_data | output | CNT_W | Selected counter value, one cycle after selection |

## Verification
A column command sampled at edge N changes its counter at that same edge N. The read port registers the pre-edge counter value, so the effect of a command shows on `rd_data` after edge N+1, and a readout request sampled at edge M is answered after edge M. The bench model follows the same order: at every rising edge it first captures the expected read value from its own pre-edge counters, then applies the command. The captured value is compared with `rd_data` at the following falling edge. Readout sweeps walk all sixteen slots so that every category, the total and the unused slots are compared after each traffic pattern.

// File: rtl/bgt_pkg.sv
package bgt_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  localparam int NUM_CAT  = 8;
  localparam int SLOTS    = NUM_CAT + 1;
  localparam int SEL_W    = 4;
  localparam int SEL_TOT  = NUM_CAT;

  // Category index: {earlier direction, later direction, group changed}
  function automatic logic [2:0] bgt_cat(input dir_e prev_dir,
                                         input dir_e cur_dir,
                                         input logic grp_diff);
    return {prev_dir, cur_dir, grp_diff};
  endfunction

endpackage

// File: rtl/bgt_sat_counter.sv
module bgt_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != MAX_VAL)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/bgt_prev_track.sv
module bgt_prev_track
  import bgt_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2,
  parameter int BG_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 cmd_valid,
  input  logic                 cmd_col,
  input  logic                 cmd_wr,
  input  logic [RANK_W-1:0]    cmd_rank,
  input  logic [BG_W-1:0]      cmd_bg,
  output logic                 inc_en,
  output logic [RANK_W-1:0]    inc_rank,
  output logic [2:0]           inc_cat,
  output logic [NUM_RANKS-1:0] prev_vld
);

  logic [NUM_RANKS-1:0] hit_rank;
  logic [NUM_RANKS-1:0] prev_wr;
  logic [BG_W-1:0]      prev_bg [NUM_RANKS];

  logic                 sel_vld;
  logic                 sel_wr;
  logic [BG_W-1:0]      sel_bg;

  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_rank
      assign hit_rank[r] = cmd_valid && cmd_col && !clr &&
                           (cmd_rank == RANK_W'(r));

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          prev_vld[r] <= 1'b0;
          prev_wr[r]  <= 1'b0;
          prev_bg[r]  <= '0;
        end else if (hit_rank[r]) begin
          prev_vld[r] <= 1'b1;
          prev_wr[r]  <= cmd_wr;
          prev_bg[r]  <= cmd_bg;
        end
      end
    end
  endgenerate

  // One-hot select of the addressed rank's remembered command
  always_comb begin
    sel_vld = 1'b0;
    sel_wr  = 1'b0;
    sel_bg  = '0;
    for (int k = 0; k < NUM_RANKS; k++) begin
      if (hit_rank[k]) begin
        sel_vld = sel_vld | prev_vld[k];
        sel_wr  = sel_wr  | prev_wr[k];
        sel_bg  = sel_bg  | prev_bg[k];
      end
    end
  end

  assign inc_en   = (|hit_rank) && sel_vld;
  assign inc_rank = cmd_rank;
  assign inc_cat  = bgt_cat(dir_e'(sel_wr), dir_e'(cmd_wr), sel_bg != cmd_bg);

endmodule

// File: rtl/bgt_rank_bank.sv
module bgt_rank_bank
  import bgt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   inc,
  input  logic [2:0]             cat,
  output logic [SLOTS*CNT_W-1:0] cnt_flat
);

  genvar c;
  generate
    for (c = 0; c < NUM_CAT; c++) begin : g_cat
      bgt_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .inc   (inc && (cat == 3'(c))),
        .count (cnt_flat[c*CNT_W +: CNT_W])
      );
    end
  endgenerate

  bgt_sat_counter #(.W(CNT_W)) u_total (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (inc),
    .count (cnt_flat[SEL_TOT*CNT_W +: CNT_W])
  );

endmodule

// File: rtl/bgt_transition_counter.sv
module bgt_transition_counter
  import bgt_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int BG_W      = 2,
  parameter int CNT_W     = 32,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmd_valid,
  input  logic              cmd_col,
  input  logic              cmd_wr,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic [BG_W-1:0]   cmd_bg,
  input  logic [RANK_W-1:0] rd_rank,
  input  logic [3:0]        rd_sel,
  output logic [CNT_W-1:0]  rd_data
);

  localparam int RANK_BITS = SLOTS * CNT_W;

  logic                       inc_en;
  logic [RANK_W-1:0]          inc_rank;
  logic [2:0]                 inc_cat;
  logic [NUM_RANKS-1:0]       prev_vld;
  logic [NUM_RANKS*RANK_BITS-1:0] all_cnt;
  logic [CNT_W-1:0]           rd_next;
  logic [CNT_W-1:0]           tot0;

  bgt_prev_track #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W),
    .BG_W      (BG_W)
  ) u_prev (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .cmd_valid (cmd_valid),
    .cmd_col   (cmd_col),
    .cmd_wr    (cmd_wr),
    .cmd_rank  (cmd_rank),
    .cmd_bg    (cmd_bg),
    .inc_en    (inc_en),
    .inc_rank  (inc_rank),
    .inc_cat   (inc_cat),
    .prev_vld  (prev_vld)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_bank
      bgt_rank_bank #(.CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .inc      (inc_en && (inc_rank == RANK_W'(r))),
        .cat      (inc_cat),
        .cnt_flat (all_cnt[r*RANK_BITS +: RANK_BITS])
      );
    end
  endgenerate

  assign tot0 = all_cnt[SEL_TOT*CNT_W +: CNT_W];

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_RANKS; k++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if ((rd_rank == RANK_W'(k)) && (rd_sel == SEL_W'(s))) begin
          rd_next = all_cnt[k*RANK_BITS + s*CNT_W +: CNT_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/bgt_checker.sv
module bgt_checker #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2,
  parameter int CNT_W     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr,
  input logic                 cmd_valid,
  input logic                 cmd_col,
  input logic                 inc_en,
  input logic [RANK_W-1:0]    inc_rank,
  input logic [NUM_RANKS-1:0] prev_vld,
  input logic [CNT_W-1:0]     tot0
);

  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  // R3: right after a clear no pair can be counted
  a_r3_no_count_after_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !inc_en);

  // R3: first cycle after reset counts nothing
  a_r3_no_count_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !inc_en);

  // R4: non-column or idle cycles never count
  a_r4_idle_no_count: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_col) |-> !inc_en);

  // R4: non-column or idle cycles keep remembered state
  a_r4_idle_keeps_prev: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(cmd_valid && cmd_col)) |=> $stable(prev_vld));

  // R9: clear empties memory and counters
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((prev_vld == '0) && (tot0 == '0)));

  // R8: total never decreases without clear
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (tot0 >= $past(tot0)));

  // R7: a counted pair on rank 0 steps the total by one
  a_r7_total_step: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !clr && (inc_rank == '0) && (tot0 != MAX_VAL))
      |=> (tot0 == $past(tot0) + 1'b1));

endmodule

bind bgt_transition_counter bgt_checker #(
  .NUM_RANKS (NUM_RANKS),
  .RANK_W    (RANK_W),
  .CNT_W     (CNT_W)
) u_bgt_checker (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .cmd_valid (cmd_valid),
  .cmd_col   (cmd_col),
  .inc_en    (inc_en),
  .inc_rank  (inc_rank),
  .prev_vld  (prev_vld),
  .tot0      (tot0)
);

// File: tb/test_bgt_transition_counter.sv
`timescale 1ns/1ps
module test_bgt_transition_counter;

  localparam int NR   = 3;
  localparam int RW   = 2;
  localparam int BGW  = 2;
  localparam int CW   = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_col = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [RW-1:0] cmd_rank = '0;
  logic [BGW-1:0] cmd_bg = '0;
  logic [RW-1:0] rd_rank = '0;
  logic [3:0]    rd_sel = '0;
  logic [CW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  int  m_cnt [NR][9];
  bit  m_vld [NR];
  bit  m_wr  [NR];
  int  m_bg  [NR];
  int  exp_rd = 0;

  always #2 clk = ~clk;  // 250 MHz

  bgt_transition_counter #(
    .NUM_RANKS (NR),
    .BG_W      (BGW),
    .CNT_W     (CW),
    .RANK_W    (RW)
  ) i_bgt_transition_counter (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .cmd_valid (cmd_valid),
    .cmd_col   (cmd_col),
    .cmd_wr    (cmd_wr),
    .cmd_rank  (cmd_rank),
    .cmd_bg    (cmd_bg),
    .rd_rank   (rd_rank),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data)
  );

  // Behavioural reference: capture readout first, then apply the command
  always @(posedge clk) begin
    int rr, ss, c;
    rr = int'(rd_rank);
    ss = int'(rd_sel);
    if (rst) exp_rd <= 0;
    else if (rr < NR && ss < 9) exp_rd <= m_cnt[rr][ss];
    else exp_rd <= 0;
    if (rst || clr) begin
      for (int i = 0; i < NR; i++) begin
        m_vld[i] = 0;
        for (int j = 0; j < 9; j++) m_cnt[i][j] = 0;
      end
    end else if (cmd_valid && cmd_col && int'(cmd_rank) < NR) begin
      rr = int'(cmd_rank);
      if (m_vld[rr]) begin
        c = (m_wr[rr] ? 4 : 0) + (cmd_wr ? 2 : 0) + ((m_bg[rr] != int'(cmd_bg)) ? 1 : 0);
        if (m_cnt[rr][c] < MAXC) m_cnt[rr][c]++;
        if (m_cnt[rr][8] < MAXC) m_cnt[rr][8]++;
      end
      m_vld[rr] = 1;
      m_wr[rr]  = cmd_wr;
      m_bg[rr]  = int'(cmd_bg);
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 2) begin
      checks++;
      if (int'(rd_data) != exp_rd) begin
        errors++;
        $display("FAIL %s: rank %0d slot %0d rd_data=%0d expected=%0d",
                 cur_req, rd_rank, rd_sel, rd_data, exp_rd);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    cmd_valid = 0; cmd_col = 0; clr = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic col(int rank, bit wr, int bg);
    cmd_valid = 1; cmd_col = 1; cmd_wr = wr;
    cmd_rank = RW'(rank); cmd_bg = BGW'(bg);
    step();
    cmd_valid = 0; cmd_col = 0;
  endtask

  task automatic noncol(int rank, int bg);
    cmd_valid = 1; cmd_col = 0; cmd_wr = 1;
    cmd_rank = RW'(rank); cmd_bg = BGW'(bg);
    step();
    cmd_valid = 0;
  endtask

  task automatic sweep(int rank);
    rd_rank = RW'(rank);
    for (int s = 0; s < 16; s++) begin
      rd_sel = 4'(s);
      step();
    end
    step();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_vld[i] = 0; m_wr[i] = 0; m_bg[i] = 0;
      for (int j = 0; j < 9; j++) m_cnt[i][j] = 0;
    end
    rst = 1;
    idle(4);
    rst = 0;
    // R1: all slots zero after reset
    cur_req = "R1";
    for (int r = 0; r < NR; r++) sweep(r);
    checks++;
    if (rd_data != '0) begin
      errors++;
      $display("FAIL R1: rd_data=%0d expected=0", rd_data);
    end

    // R3: first column command only loads memory
    cur_req = "R3";
    col(0, 0, 0);
    idle(1);
    sweep(0);

    // R2 and R6: every category on rank 0
    cur_req = "R2";
    col(0, 0, 0); col(0, 0, 1); col(0, 1, 1); col(0, 1, 1);
    col(0, 1, 2); col(0, 0, 2); col(0, 1, 3); col(0, 0, 0);
    idle(1);
    sweep(0);
    cur_req = "R6";
    col(0, 0, 3); col(0, 0, 2);
    idle(1);
    sweep(0);

    // R4: idle, non-column, and out-of-range rank leave memory alone
    cur_req = "R4";
    noncol(0, 1);
    cmd_valid = 0; cmd_col = 1; cmd_wr = 1; cmd_bg = 2'd0; step(); cmd_col = 0;
    col(3, 1, 1);
    col(0, 0, 2);   // earlier stays read bg2 -> slot 0
    idle(1);
    sweep(0);

    // R5: interleaved ranks keep separate memories
    cur_req = "R5";
    col(1, 1, 0); col(2, 0, 3); col(1, 1, 0); col(2, 0, 1);
    col(0, 1, 2); col(1, 0, 1); col(2, 1, 1);
    idle(1);
    sweep(1); sweep(2); sweep(0);

    // R9: clear drops a same-cycle command, next command only loads
    cur_req = "R9";
    clr = 1; cmd_valid = 1; cmd_col = 1; cmd_wr = 1; cmd_rank = 2'd1; cmd_bg = 2'd0;
    step();
    clr = 0; cmd_valid = 0; cmd_col = 0;
    col(1, 0, 0);
    col(0, 1, 1);
    idle(1);
    sweep(1); sweep(0);

    // R8: saturation of a category and of the total
    cur_req = "R8";
    for (int i = 0; i < 40; i++) col(2, 1, 3);
    idle(1);
    sweep(2);

    // R7: mixed traffic, total against sum of categories
    cur_req = "R7";
    clr = 1; step(); clr = 0;
    for (int i = 0; i < 300; i++) begin
      cmd_valid = ($urandom % 5) != 0;
      cmd_col   = ($urandom % 4) != 0;
      cmd_wr    = 1'($urandom);
      cmd_rank  = RW'($urandom % 3);
      cmd_bg    = BGW'($urandom);
      rd_rank   = RW'($urandom % 3);
      rd_sel    = 4'($urandom % 10);
      step();
    end
    idle(1);
    sweep(0); sweep(1);

    // R10: unused slots and ranks read zero, one-cycle latency
    cur_req = "R10";
    sweep(3);
    rd_rank = 2'd0; rd_sel = 4'd15; step();
    rd_sel = 4'd8; step(); step();

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule